// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits, with separate strobes for the upper and lower byte. The host offers one word-sized request at a time over a valid/ready handshake. Each request carries an 18-bit word address, a read/write flag, 16 bits of write data and a 2-bit lane mask. The controller turns each accepted request into a sequence of registered, active-low chip-enable, write-enable, output-enable and lane strobes. It drives a split data bus made of an outgoing word, a drive enable and an incoming word.

Every timing window is a whole number of clock cycles set by a parameter: the write-pulse length, the read-access length and the idle gap after an operation, each at least 1. A read returns the sampled word with a one-cycle strobe. The output enable stays high through the whole write cycle, so the shorter write-pulse rule applies. The controller's data drivers and the RAM's outputs are never enabled in the same cycle, and a full idle cycle always separates them.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip-enable, write-enable, output-enable and both lane strobes are high, the data drive enable is low, ready is high and the read strobe is low.
- R2: Ready is high only while the controller is idle. An accepted read keeps ready low for RD_ACC_CYC+TURN_CYC cycles, and an accepted write keeps it low for 1+WR_PULSE_CYC+TURN_CYC cycles. A request presented while ready is low is ignored and never reaches the RAM.
- R3: A read holds chip-enable and output-enable low with write-enable high for exactly RD_ACC_CYC cycles. It samples the data input at the end of the last of these cycles. The read strobe then goes high for one cycle, in the first cycle after output-enable rises.
- R4: A write first holds chip-enable low, drives the data and keeps write-enable high for one setup cycle. It then holds write-enable low for exactly WR_PULSE_CYC cycles. Output-enable stays high throughout.
- R5: Mask bit 0 set makes the low-byte strobe (data bits 7:0) low during the operation, and mask bit 1 set does the same for the high-byte strobe (bits 15:8). A lane with a clear mask bit is neither written nor driven by the RAM. Both lane strobes are high outside an operation.
- R6: The memory address changes only while chip-enable and write-enable were high in the previous cycle. It stays unchanged while chip-enable is low.
- R7: The data drive enable and a low output-enable never occur in the same cycle. Each switches on only in a cycle after the other was off.
- R8: While write-enable is low, the data bus is driven and its value does not change, and it was already driven in the cycle before.
- R9: After every operation, chip-enable stays high for at least TURN_CYC cycles before the next operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 16 | Read data |
| mem_addr_o | output | 18 | RAM address |
| mem_ce_no | output | 1 | RAM chip enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_ub_no | output | 1 | RAM high-byte strobe, active low |
| mem_lb_no | output | 1 | RAM low-byte strobe, active low |
| mem_dq_o | output | 16 | Data toward RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from RAM |

## Verification
The hardest case to reach is the handover of the shared data pins between back-to-back operations of opposite direction. The controller's drivers must turn off and the RAM's outputs turn on, or the reverse, with an idle cycle between them. The stimulus issues writes and reads in alternating order, with the host presenting the next request as soon as ready returns. An attached RAM model stores a word only on the rising write-enable edge, and a pin monitor counts the cycles where both sides drive. The model also returns a marker byte on disabled lanes. Partial-lane writes and reads are then visible as data values, and so is a request presented during a busy cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_TURN
  } sram_st_e;
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] lane_no
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_no[g] <= 1'b1;
      else         lane_no[g] <= ~(active_i & mask_i[g]);
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int WR_PULSE_CYC = 2,
  parameter int RD_ACC_CYC   = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_ce_no,
  output logic                mem_we_no,
  output logic                mem_oe_no,
  output logic                mem_ub_no,
  output logic                mem_lb_no,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [DATA_W-1:0]   mem_dq_i
);
  localparam int LANES   = DATA_W / 8;
  localparam int MAX_A   = (WR_PULSE_CYC > RD_ACC_CYC) ? WR_PULSE_CYC : RD_ACC_CYC;
  localparam int CNT_MAX = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sram_st_e         st_q, st_d;
  logic             accept, t_load, t_zero, active_d, rd_last;
  logic [CNT_W-1:0] t_val;
  logic [LANES-1:0] mask_q, mask_d, lane_n;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;
  assign rd_last     = (st_q == ST_RD_WAIT) & t_zero;
  assign mask_d      = accept ? req_be_i : mask_q;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        t_load = 1'b1;
        if (req_write_i) begin
          st_d  = ST_WR_SETUP;
          t_val = CNT_W'(WR_PULSE_CYC);   // setup cycle consumes one count
        end else begin
          st_d  = ST_RD_WAIT;
          t_val = CNT_W'(RD_ACC_CYC - 1);
        end
      end
      ST_RD_WAIT, ST_WR_PULSE: if (t_zero) begin
        st_d   = ST_TURN;
        t_load = 1'b1;
        t_val  = CNT_W'(TURN_CYC - 1);
      end
      ST_WR_SETUP: st_d = ST_WR_PULSE;
      ST_TURN:     if (t_zero) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  assign active_d = (st_d == ST_RD_WAIT) | (st_d == ST_WR_SETUP) | (st_d == ST_WR_PULSE);

  sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  sram_ctrl_lanes #(.LANES(LANES)) i_lanes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active_d),
    .mask_i   (mask_d),
    .lane_no  (lane_n)
  );

  assign mem_lb_no = lane_n[0];
  assign mem_ub_no = lane_n[LANES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      mask_q      <= '0;
      mem_addr_o  <= '0;
      mem_dq_o    <= '0;
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      st_q        <= st_d;
      mask_q      <= mask_d;
      mem_ce_no   <= ~active_d;
      mem_oe_no   <= ~(st_d == ST_RD_WAIT);
      mem_we_no   <= ~(st_d == ST_WR_PULSE);
      mem_dq_oe_o <= (st_d == ST_WR_SETUP) | (st_d == ST_WR_PULSE);
      rsp_valid_o <= rd_last;
      if (accept) begin
        mem_addr_o <= req_addr_i;
        if (req_write_i) mem_dq_o <= req_wdata_i;
      end
      if (rd_last) rsp_rdata_o <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int WR_PULSE_CYC = 2,
  parameter int RD_ACC_CYC   = 2,
  parameter int TURN_CYC     = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_ub_no,
  input logic              mem_lb_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  int we_low_cnt, oe_low_cnt, ce_high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt  <= 0;
      oe_low_cnt  <= 0;
      ce_high_cnt <= TURN_CYC;
    end else begin
      we_low_cnt  <= mem_we_no ? 0 : we_low_cnt + 1;
      oe_low_cnt  <= mem_oe_no ? 0 : oe_low_cnt + 1;
      ce_high_cnt <= !mem_ce_no ? 0 : (ce_high_cnt < TURN_CYC ? ce_high_cnt + 1 : ce_high_cnt);
    end
  end

  // R1
  idle_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_no && mem_we_no && mem_oe_no && mem_ub_no && mem_lb_no && !mem_dq_oe_o);
  // R3
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R3
  rsp_after_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> mem_oe_no && !$past(mem_oe_no));
  // R3
  oe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> oe_low_cnt == RD_ACC_CYC);
  // R4
  we_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> we_low_cnt == WR_PULSE_CYC);
  // R4
  we_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no && mem_oe_no);
  // R5
  lane_in_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> mem_ub_no && mem_lb_no);
  // R6
  addr_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> $past(mem_ce_no) && $past(mem_we_no) && mem_we_no);
  // R7
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));
  // R7
  oe_after_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> !$past(mem_dq_oe_o));
  // R7
  drv_after_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));
  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_dq_oe_o && $past(mem_dq_oe_o) && $stable(mem_dq_o));
  // R9
  turn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $past(ce_high_cnt) >= TURN_CYC);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_PULSE_CYC(WR_PULSE_CYC),
  .RD_ACC_CYC(RD_ACC_CYC), .TURN_CYC(TURN_CYC)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no),
  .mem_oe_no(mem_oe_no), .mem_ub_no(mem_ub_no), .mem_lb_no(mem_lb_no),
  .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int AW = 18, DW = 16, WRC = 2, RDC = 2, TRC = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_valid;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, mem_dq_o, mem_dq_i;
  logic [1:0]    req_be = '0;
  logic          ce_n, we_n, oe_n, ub_n, lb_n, dq_oe;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WR_PULSE_CYC(WRC), .RD_ACC_CYC(RDC), .TURN_CYC(TRC)) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_addr_o(mem_addr),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // RAM model: stores on rising write enable, disabled lanes read back as EE
  logic [DW-1:0] ram [int];
  logic [DW-1:0] shadow [int];
  bit pend = 1'b0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic [1:0]    p_lane_n;

  function automatic logic [DW-1:0] ram_rd(logic [AW-1:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 16'h0000;
  endfunction
  function automatic logic [DW-1:0] sh_rd(logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  always @(*) begin
    logic [DW-1:0] w;
    w = ram_rd(mem_addr);
    if (!ce_n && !oe_n && we_n)
      mem_dq_i = {ub_n ? 8'hEE : w[15:8], lb_n ? 8'hEE : w[7:0]};
    else
      mem_dq_i = 16'h0000;
  end

  always @(negedge clk) begin
    if (!we_n && !ce_n) begin
      pend = 1'b1; p_addr = mem_addr; p_data = mem_dq_o; p_lane_n = {ub_n, lb_n};
    end else if (pend && we_n) begin
      logic [DW-1:0] w;
      w = ram_rd(p_addr);
      if (!p_lane_n[0]) w[7:0]  = p_data[7:0];
      if (!p_lane_n[1]) w[15:8] = p_data[15:8];
      ram[int'(p_addr)] = w;
      pend = 1'b0;
    end
  end

  // pin monitor: pulse widths, contention, address stability, idle gap
  int we_run = 0, oe_run = 0, ce_hi_run = 100;
  logic prev_ce_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !oe_n) chk("R7 contention", 1, 0);
    if (!we_n) we_run++;
    else if (we_run != 0) begin chk("R4 we low cycles", we_run, WRC); we_run = 0; end
    if (!oe_n) oe_run++;
    else if (oe_run != 0) begin chk("R3 oe low cycles", oe_run, RDC); oe_run = 0; end
    if (!ce_n && !prev_ce_n && mem_addr !== prev_addr) chk("R6 addr moved under ce", 1, 0);
    if (!ce_n && prev_ce_n) chk("R9 idle gap ok", ce_hi_run >= TRC, 1);
    ce_hi_run = ce_n ? ce_hi_run + 1 : 0;
    prev_ce_n = ce_n;
    prev_addr = mem_addr;
  end

  // scoreboard
  logic [DW-1:0] exp_q [$];
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) chk("R3 unexpected rsp", 1, 0);
    else chk("R3/R5 read data", rsp_rdata, exp_q.pop_front());
  end

  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] be, int busy_exp);
    int n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
    chk("R2 busy cycles", n, busy_exp);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] be);
    logic [DW-1:0] w;
    w = sh_rd(a);
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    shadow[int'(a)] = w;
    issue(1'b1, a, d, be, 1 + WRC + TRC);
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [1:0] be);
    logic [DW-1:0] w;
    w = sh_rd(a);
    exp_q.push_back({be[1] ? w[15:8] : 8'hEE, be[0] ? w[7:0] : 8'hEE});
    issue(1'b0, a, '0, be, RDC + TRC);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce", ce_n, 1); chk("R1 we", we_n, 1); chk("R1 oe", oe_n, 1);
    chk("R1 lanes", {ub_n, lb_n}, 2'b11); chk("R1 dq_oe", dq_oe, 0);
    chk("R1 ready", req_ready, 1); chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_write(18'h00000, 16'hA5C3, 2'b11);
    do_read (18'h00000, 2'b11);
    do_write(18'h3FFFF, 16'h1234, 2'b11);
    do_read (18'h3FFFF, 2'b11);
    // R5 partial lanes
    do_write(18'h00100, 16'hBEEF, 2'b11);
    do_write(18'h00100, 16'h7766, 2'b01);
    do_read (18'h00100, 2'b11);
    do_write(18'h00100, 16'h5544, 2'b10);
    do_read (18'h00100, 2'b11);
    do_read (18'h00100, 2'b01);
    do_read (18'h00100, 2'b10);
    do_write(18'h00200, 16'hFFFF, 2'b00);
    do_read (18'h00200, 2'b11);

    // R2 request during busy is ignored
    do_write(18'h00300, 16'h0F0F, 2'b11);
    while (!req_ready) @(negedge clk);
    shadow[int'(18'h00005)] = 16'h1111;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00005; req_wdata = 16'h1111; req_be = 2'b11;
    @(negedge clk);
    req_addr = 18'h00300; req_wdata = 16'hBAD0;
    chk("R2 ready low while busy", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    do_read(18'h00300, 2'b11);
    do_read(18'h00005, 2'b11);

    // R7 alternating directions back to back
    for (int i = 0; i < 8; i++) begin
      do_write(18'(i * 37 + 9), 16'(i * 16'h1357), 2'b11);
      do_read (18'(i * 37 + 9), 2'b11);
    end

    repeat (4) @(negedge clk);
    chk("R3 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end
endmodule